// File: doc/BRIEF.md
# BCD Decoder with Polarity Control

This block takes a four-bit binary-coded-decimal address and turns it into one active line out of ten. Two gate inputs of opposite sense must both be asserted before any line can go active. A polarity input chooses the active level. With the polarity low, the selected line is high and the other nine are low. With the polarity high, the selected line is low and the other nine are high. Addresses from ten to fifteen are not valid decimal digits, so no line goes active for them.

The outputs are meant to drive a shared net through three-state buffers. The block does not produce high-impedance values itself. It produces a ten-bit level vector and a ten-bit drive-enable vector, and a pad or wrapper level applies them. An active-low output enable controls the drive vector and overrides every other input.

A gate input can also carry a data stream instead of a static enable. The stream then appears on the addressed line: unchanged when it is on the active-high gate, inverted when it is on the active-low gate, and inverted again if the polarity is high. The block is purely combinational, so the outputs follow the inputs within the same evaluation step.

Top module: `bcd_decode_demux`

## Requirements
- R1: With `oe_ni`=0, `en_n_i`=0, `en_i`=1, `pol_i`=0 and `addr_i` from 0 to 9, `data_o` is one-hot, and bit `addr_i` is 1.
- R2: With the same conditions as R1 but `pol_i`=1, `data_o` is one-cold, and bit `addr_i` is 0.
- R3: For `addr_i` from 10 to 15, every bit of `data_o` equals `pol_i`, whatever the gate inputs are.
- R4: While `en_n_i`=1, every bit of `data_o` equals `pol_i`.
- R5: While `en_i`=0, every bit of `data_o` equals `pol_i`.
- R6: `drv_o` is all ones while `oe_ni`=0 and all zeros while `oe_ni`=1, whatever the other inputs are.
- R7: `oe_ni` has no effect on `data_o`. For the same other inputs, `data_o` is identical for `oe_ni`=0 and for `oe_ni`=1.
- R8: With `addr_i` valid, a data bit d on `en_i` (and `en_n_i`=0) gives `data_o[addr_i]` = d XOR `pol_i`. A data bit d on `en_n_i` (and `en_i`=1) gives `data_o[addr_i]` = NOT d XOR `pol_i`.
- R9: At any time, at most one bit of `data_o` differs from `pol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 4 | BCD address; codes 10 to 15 are invalid |
| en_n_i | input | 1 | Active-low gate, can carry demultiplexed data |
| en_i | input | 1 | Active-high gate, can carry demultiplexed data |
| pol_i | input | 1 | 0: active-high outputs, 1: active-low outputs |
| oe_ni | input | 1 | Active-low output enable for all ten lines |
| data_o | output | 10 | Output levels, bit n is line n |
| drv_o | output | 10 | Per-line drive enable, 1 = drive `data_o` onto the pin |

## Verification
The hardest case to reach is the demultiplexing use, where a gate input switches between vectors while the address and polarity stay fixed. An exhaustive sweep only ever visits static combinations, so it never exercises a gate acting as a data stream. The bench therefore holds each of several addresses, once per polarity, and toggles one gate at a time through a bit pattern, checking the addressed line after each toggle. To show that the output enable has no effect on the levels, the bench stores the result of every vector with `oe_ni` low and compares it with the same vector repeated with `oe_ni` high.

// File: rtl/bcd_dec_pkg.sv
package bcd_dec_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NUM_OUT = 10;
endpackage

// File: rtl/bcd_addr_decode.sv
module bcd_addr_decode #(
  parameter int unsigned ADDR_W  = bcd_dec_pkg::ADDR_W,
  parameter int unsigned NUM_OUT = bcd_dec_pkg::NUM_OUT
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_OUT-1:0] hot_o
);
  // codes at or above NUM_OUT match no line
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
    assign hot_o[g] = (addr_i == ADDR_W'(g));
  end
endmodule

// File: rtl/bcd_enable_gate.sv
module bcd_enable_gate #(
  parameter int unsigned NUM_OUT = bcd_dec_pkg::NUM_OUT
) (
  input  logic               en_n_i,
  input  logic               en_i,
  input  logic [NUM_OUT-1:0] hot_i,
  output logic [NUM_OUT-1:0] sel_o
);
  logic gate_on;
  assign gate_on = ~en_n_i & en_i;
  assign sel_o   = hot_i & {NUM_OUT{gate_on}};
endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage #(
  parameter int unsigned NUM_OUT = bcd_dec_pkg::NUM_OUT
) (
  input  logic [NUM_OUT-1:0] sel_i,
  input  logic               pol_i,
  input  logic               oe_ni,
  output logic [NUM_OUT-1:0] data_o,
  output logic [NUM_OUT-1:0] drv_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
    assign data_o[g] = sel_i[g] ^ pol_i;
    assign drv_o[g]  = ~oe_ni;
  end
endmodule

// File: rtl/bcd_decode_demux.sv
module bcd_decode_demux #(
  parameter int unsigned ADDR_W  = bcd_dec_pkg::ADDR_W,
  parameter int unsigned NUM_OUT = bcd_dec_pkg::NUM_OUT
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               en_n_i,
  input  logic               en_i,
  input  logic               pol_i,
  input  logic               oe_ni,
  output logic [NUM_OUT-1:0] data_o,
  output logic [NUM_OUT-1:0] drv_o
);
  logic [NUM_OUT-1:0] hot;
  logic [NUM_OUT-1:0] sel;

  bcd_addr_decode #(.ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)) u_dec (
    .addr_i(addr_i),
    .hot_o (hot)
  );

  bcd_enable_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .en_n_i(en_n_i),
    .en_i  (en_i),
    .hot_i (hot),
    .sel_o (sel)
  );

  bcd_out_stage #(.NUM_OUT(NUM_OUT)) u_out (
    .sel_i (sel),
    .pol_i (pol_i),
    .oe_ni (oe_ni),
    .data_o(data_o),
    .drv_o (drv_o)
  );
endmodule

// File: rtl/bcd_decode_demux_chk.sv
module bcd_decode_demux_chk #(
  parameter int unsigned ADDR_W  = bcd_dec_pkg::ADDR_W,
  parameter int unsigned NUM_OUT = bcd_dec_pkg::NUM_OUT
) (
  input logic [ADDR_W-1:0]  addr_i,
  input logic               en_n_i,
  input logic               en_i,
  input logic               pol_i,
  input logic               oe_ni,
  input logic [NUM_OUT-1:0] data_o,
  input logic [NUM_OUT-1:0] drv_o
);
  logic [NUM_OUT-1:0] diff;
  logic               addr_ok;
  logic               hit_lvl;

  always_comb begin
    diff    = data_o ^ {NUM_OUT{pol_i}};
    addr_ok = (32'(addr_i) < NUM_OUT);
    hit_lvl = pol_i;
    for (int i = 0; i < NUM_OUT; i++)
      if (32'(addr_i) == i) hit_lvl = data_o[i];
  end

  always_comb begin
    AST_AT_MOST_ONE: assert ($countones(diff) <= 1); // R9
    if (!addr_ok) AST_BAD_CODE_IDLE: assert (diff == '0); // R3
    if (en_n_i) AST_LOW_GATE_IDLE: assert (diff == '0); // R4
    if (!en_i) AST_HIGH_GATE_IDLE: assert (diff == '0); // R5
    if (addr_ok && !en_n_i && en_i) AST_HIT_ACTIVE: assert (hit_lvl != pol_i); // R1
    AST_DRIVE_ALL: assert ($countones(drv_o) == (oe_ni ? 0 : NUM_OUT)); // R6
  end
endmodule

bind bcd_decode_demux bcd_decode_demux_chk #(.ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)) u_chk (.*);

// File: tb/sim_bcd_decode_demux.sv
`timescale 1ns/1ps
module sim_bcd_decode_demux;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic       en_n_i = 1'b1;
  logic       en_i = 1'b0;
  logic       pol_i = 1'b0;
  logic       oe_ni = 1'b1;
  logic [9:0] data_o;
  logic [9:0] drv_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [9:0] stash [128];

  always #10 clk = ~clk;

  bcd_decode_demux u0 (.*);

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic o, input logic e1, input logic e2, input logic p, input logic [3:0] a);
    @(posedge clk);
    oe_ni = o; en_n_i = e1; en_i = e2; pol_i = p; addr_i = a;
    @(negedge clk);
  endtask

  function automatic logic [9:0] model(input logic e1, input logic e2, input logic p, input int a);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = p;
    if (!e1 && e2 && a < 10) r[a] = ~p;
    return r;
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // initial state: output disabled, gates closed
    chk("R6", drv_o, 10'h000);
    chk("R4", data_o, 10'h000);

    for (int v = 0; v < 256; v++) begin
      logic o, e1, e2, p;
      int a;
      string tag;
      int nd;
      o = v[7]; e1 = v[6]; e2 = v[5]; p = v[4]; a = v & 15;
      apply(o, e1, e2, p, 4'(a));
      if (a >= 10) tag = "R3";
      else if (e1) tag = "R4";
      else if (!e2) tag = "R5";
      else tag = p ? "R2" : "R1";
      chk(tag, data_o, model(e1, e2, p, a));
      chk("R6", drv_o, o ? 10'h000 : 10'h3ff);
      nd = $countones(data_o ^ {10{p}});
      chk("R9", 10'(nd > 1), 10'd0);
      if (!o) stash[v[6:0]] = data_o;
      else chk("R7", data_o, stash[v[6:0]]);
    end

    // demultiplexing: data on one gate, other gate held active
    for (int k = 0; k < 4; k++) begin
      int a;
      logic p;
      a = (k * 3) % 10;
      p = k[0];
      for (int b = 0; b < 6; b++) begin
        logic d;
        logic [9:0] e;
        d = 1'((6'b101101 >> b) & 1);
        apply(1'b0, 1'b0, d, p, 4'(a));
        e = {10{p}}; e[a] = d ^ p;
        chk("R8", data_o, e);
        apply(1'b0, d, 1'b1, p, 4'(a));
        e = {10{p}}; e[a] = ~d ^ p;
        chk("R8", data_o, e);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule